// File: doc/BRIEF.md
# Row/Column Decoded Byte Memory

A 256-entry, 8-bit-wide memory. Each byte lives in its own register, and the registers sit in a 16 x 16 grid. The block has an address register, which is loaded from the address input under its own strobe. The upper half of the held address picks a row line and the lower half picks a column line. Only the byte register where the active row meets the active column is selected.

All cells share a single data bus. That bus is the OR of the external data input and the output of whichever cell is currently enabled for reading. A global store strobe loads the bus into the selected cell on the next rising clock edge. A global read strobe places the selected cell onto the bus.

The resolved bus is brought out as a read-data port, so no port is bidirectional. To write: load the address, put data on the input, pulse the store strobe. To read: load the address, raise the read strobe, sample the read-data port.

Top module: `grid_ram`

## Requirements
- R1: A synchronous active-low reset clears the address register and every cell to zero. After reset, a read with the external input at zero returns 0x00.
- R2: The address register loads `addr_in` on a rising edge only while `addr_set` is high. It keeps its value while `addr_set` is low, so changing `addr_in` alone does not change the selected cell.
- R3: Bits [7:4] of the held address feed one 4-to-16 one-hot decoder and bits [3:0] feed another. Each decoder has exactly one output high at all times.
- R4: A cell is selected only when both its row line and its column line are high. Exactly one of the 256 cells is selected, and each address reaches its own cell.
- R5: On a rising edge with `io_set` high, the selected cell loads the resolved bus value. No other cell changes.
- R6: While `io_set` is low, no cell changes, whatever `io_in` holds.
- R7: `rd_data` equals `io_in` when `io_en` is low. It equals `io_in` OR the selected cell's content when `io_en` is high.
- R8: With `io_set` and `io_en` both high, the selected cell stores `io_in` OR its own previous content.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_in | input | 8 | Address to load into the address register |
| addr_set | input | 1 | Load strobe for the address register |
| io_in | input | 8 | External driver of the shared bus (write data) |
| io_set | input | 1 | Global store strobe, gated per cell by its select |
| io_en | input | 1 | Global read strobe, gated per cell by its select |
| rd_data | output | 8 | Resolved bus value |

## Verification
Bytes are written to addresses that differ only in the row nibble or only in the column nibble. Read-back then shows whether the two decoders and the AND in each cell keep those cells apart. A full sweep writes a value that depends on the address into all 256 cells, then reads every one. This catches any aliasing or swapped nibble in the decode.

Separate patterns target the hold behaviour:
- changing the address input with its strobe low;
- driving the bus with the store strobe low;
- asserting both strobes together, so that the OR of external data with the stored byte is written back.

A second reset after the memory has been filled shows that reset clears the cells and not just the address.

// File: rtl/grid_ram_pkg.sv
// Shared constants and types for the row/column decoded byte memory.
// Assumes an 8-bit data path and square grid by default; top-level
// parameters may override the widths.
package grid_ram_pkg;
    localparam int unsigned DEF_DATA_W    = 8;
    localparam int unsigned DEF_SIDE_BITS = 4;

    // Per-cell gated strobes derived from the grid select.
    typedef struct packed {
        logic store;
        logic drive;
    } cell_ctl_t;
endpackage

// File: rtl/addr_latch.sv
// Address register: loads d on a rising edge while set is high, holds
// otherwise. Assumes synchronous active-low reset to zero.
module addr_latch #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Hold or load the address.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (set) q <= d;
    end

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !set |=> q == $past(q));
    // R2
    addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> q == $past(d));
endmodule

// File: rtl/onehot_decoder.sv
// Binary to one-hot decoder with 2**IN_W outputs. Purely combinational;
// clk and rst_n exist only to clock its check.
module onehot_decoder #(
    parameter int unsigned IN_W = 4,
    localparam int unsigned OUT_N = 1 << IN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IN_W-1:0]  sel,
    output logic [OUT_N-1:0] lines
);
    // One comparator per output line.
    for (genvar g = 0; g < OUT_N; g++) begin : g_line
        assign lines[g] = (sel == IN_W'(g));
    end

    // R3
    dec_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(lines));
endmodule

// File: rtl/grid_cell.sv
// One byte register at a row/column crossing. Selected when both lines
// are high; store and drive are the select gated by the global strobes.
// Output is zero unless driving. Assumes synchronous active-low reset.
module grid_cell
    import grid_ram_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         row,
    input  logic         col,
    input  logic         io_set,
    input  logic         io_en,
    input  logic [W-1:0] bus_in,
    output logic         sel_o,
    output logic [W-1:0] drv_o
);
    cell_ctl_t    ctl;
    logic [W-1:0] q;

    // Grid select and gated strobes.
    always_comb begin
        sel_o     = row & col;
        ctl.store = sel_o & io_set;
        ctl.drive = sel_o & io_en;
    end

    // Byte storage.
    always_ff @(posedge clk) begin
        if (!rst_n)         q <= '0;
        else if (ctl.store) q <= bus_in;
    end

    // Enabler: zero unless this cell drives the bus.
    assign drv_o = ctl.drive ? q : '0;

    // R5
    cell_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (row && col && io_set) |=> q == $past(bus_in));
    // R6
    cell_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(row && col && io_set) |=> $stable(q));
endmodule

// File: rtl/grid_ram.sv
// Top: address register, row and column decoders, a grid of byte cells
// and an OR-resolved shared bus exposed as rd_data. Assumes all strobes
// are synchronous to clk.
module grid_ram
    import grid_ram_pkg::*;
#(
    parameter int unsigned DATA_W    = DEF_DATA_W,
    parameter int unsigned SIDE_BITS = DEF_SIDE_BITS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2*SIDE_BITS-1:0] addr_in,
    input  logic                   addr_set,
    input  logic [DATA_W-1:0]      io_in,
    input  logic                   io_set,
    input  logic                   io_en,
    output logic [DATA_W-1:0]      rd_data
);
    localparam int unsigned ADDR_W = 2 * SIDE_BITS;
    localparam int unsigned SIDE_N = 1 << SIDE_BITS;
    localparam int unsigned CELLS  = SIDE_N * SIDE_N;

    logic [ADDR_W-1:0] addr_q;
    logic [SIDE_N-1:0] row_ln;
    logic [SIDE_N-1:0] col_ln;
    logic [CELLS-1:0]  sel_vec;
    logic [DATA_W-1:0] cell_drv [CELLS];
    logic [DATA_W-1:0] cells_or;
    logic [DATA_W-1:0] bus;

    addr_latch #(.W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .set(addr_set), .d(addr_in), .q(addr_q)
    );

    onehot_decoder #(.IN_W(SIDE_BITS)) u_row_dec (
        .clk(clk), .rst_n(rst_n),
        .sel(addr_q[ADDR_W-1:SIDE_BITS]), .lines(row_ln)
    );

    onehot_decoder #(.IN_W(SIDE_BITS)) u_col_dec (
        .clk(clk), .rst_n(rst_n),
        .sel(addr_q[SIDE_BITS-1:0]), .lines(col_ln)
    );

    for (genvar r = 0; r < SIDE_N; r++) begin : g_row
        for (genvar c = 0; c < SIDE_N; c++) begin : g_col
            grid_cell #(.W(DATA_W)) u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .row    (row_ln[r]),
                .col    (col_ln[c]),
                .io_set (io_set),
                .io_en  (io_en),
                .bus_in (bus),
                .sel_o  (sel_vec[r*SIDE_N + c]),
                .drv_o  (cell_drv[r*SIDE_N + c])
            );
        end
    end

    // OR together every cell's gated output.
    always_comb begin
        cells_or = '0;
        for (int i = 0; i < CELLS; i++) cells_or |= cell_drv[i];
    end

    // Resolve the bus from external driver and enabled cell.
    assign bus     = io_in | cells_or;
    assign rd_data = bus;

    // R4
    one_cell_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sel_vec) == 1);
    // R7
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !io_en |-> rd_data == io_in);
endmodule

// File: tb/grid_ram_test.sv
// Scoreboard bench: driver tasks push expected read values; a monitor
// pops and compares while io_en is high.
module grid_ram_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr_in = '0;
    logic       addr_set = 1'b0;
    logic [7:0] io_in = '0;
    logic       io_set = 1'b0;
    logic       io_en = 1'b0;
    logic [7:0] rd_data;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } exp_t;

    exp_t       sb[$];
    logic [7:0] model [256];
    logic [7:0] cur;
    int         n_cmp = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    grid_ram uut (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .addr_set(addr_set),
        .io_in(io_in), .io_set(io_set), .io_en(io_en), .rd_data(rd_data)
    );

    task automatic check(input string tag, input logic [7:0] act,
                         input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // Monitor: compares the bus against the scoreboard head.
    always @(negedge clk) begin
        exp_t e;
        #1;
        if (rst_n && io_en && sb.size() > 0) begin
            e = sb.pop_front();
            check(e.tag, rd_data, e.exp);
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; addr_set = 0; io_set = 0; io_en = 0; io_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 256; i++) model[i] = '0;
        cur = '0;
    endtask

    task automatic set_addr(input logic [7:0] a);
        @(negedge clk);
        addr_in = a; addr_set = 1'b1;
        @(negedge clk);
        addr_set = 1'b0;
        cur = a;
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        io_in = d; io_set = 1'b1;
        @(negedge clk);
        io_set = 1'b0; io_in = '0;
        model[cur] = d;
    endtask

    task automatic rd(input logic [7:0] drv, input string tag);
        @(negedge clk);
        io_in = drv; io_en = 1'b1;
        sb.push_back('{exp: drv | model[cur], tag: tag});
        @(negedge clk);
        io_en = 1'b0; io_in = '0;
    endtask

    initial begin
        do_reset();
        // R1: reset state reads zero at address 0.
        rd(8'h00, "R1 reset read");

        // R5: basic write and read-back.
        set_addr(8'h00); wr(8'h11); rd(8'h00, "R5 write addr 00");

        // R4: addresses differing only in row or column nibble.
        set_addr(8'h12); wr(8'hAA);
        set_addr(8'h21); wr(8'h55);
        set_addr(8'h13); wr(8'h3C);
        set_addr(8'h02); wr(8'h81);
        set_addr(8'h12); rd(8'h00, "R4 cell 12");
        set_addr(8'h21); rd(8'h00, "R4 cell 21");
        set_addr(8'h13); rd(8'h00, "R4 cell 13");
        set_addr(8'h02); rd(8'h00, "R4 cell 02");

        // R2: address input moves while strobe low.
        set_addr(8'h12);
        @(negedge clk); addr_in = 8'h21;
        repeat (2) @(negedge clk);
        rd(8'h00, "R2 hold address");

        // R6: bus driven without store strobe.
        @(negedge clk); io_in = 8'hFF;
        repeat (3) @(negedge clk);
        io_in = 8'h00;
        rd(8'h00, "R6 no store");

        // R7: bus with read strobe low follows io_in.
        @(negedge clk); io_in = 8'h0C;
        #1 check("R7 idle bus", rd_data, 8'h0C);
        set_addr(8'h21);
        rd(8'h80, "R7 merged read");

        // R8: both strobes high at once.
        set_addr(8'h13);
        @(negedge clk);
        io_in = 8'hC1; io_en = 1'b1; io_set = 1'b1;
        sb.push_back('{exp: 8'hFD, tag: "R8 bus during merge"});
        @(negedge clk);
        io_in = '0; io_en = 1'b0; io_set = 1'b0;
        model[8'h13] = 8'hFD;
        rd(8'h00, "R8 merged store");

        // R3 R4: full sweep.
        for (int a = 0; a < 256; a++) begin
            set_addr(8'(a)); wr(8'(a) ^ 8'hA7);
        end
        for (int a = 0; a < 256; a++) begin
            set_addr(8'(a)); rd(8'h00, "R3 R4 sweep");
        end

        // R1: reset clears filled cells.
        do_reset();
        rd(8'h00, "R1 addr after reset");
        set_addr(8'hFF); rd(8'h00, "R1 cell FF cleared");
        set_addr(8'h5A); rd(8'h00, "R1 cell 5A cleared");

        repeat (2) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (50000) @(posedge clk);
                n_cmp++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        if (sb.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL scoreboard: actual %0d left expected 0", sb.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule